// File: doc/BRIEF.md
# Key-Locked Watchdog Timer

This block is a watchdog timer reached through a flat register port: a word address, a write strobe, write data and a combinational read-data bus. A free-running 31-bit counter advances once per clock while the selected run mode allows it. A three-bit scale field picks which 16-bit slice of the counter is tested against a 16-bit compare value. When that slice reaches or passes the compare value, a sticky pending flag is set and drives the interrupt output. The match can also return the counter to zero, which gives a periodic interrupt, or it can issue a one-cycle reset request.

Every register write is guarded. A write of a fixed unlock code to the key register arms exactly one following write. Any other write, accepted or not, disarms the guard again. Clearing the counter in normal service takes a separate feed code, written to the feed register just after an unlock. Reads are never guarded.

Top module: `kwdt_top`

## Requirements
- R1: Writes to the config (address 0), counter (1), compare (2) and feed (3) registers take effect only when the write just before them was the unlock code 0x0051F15E written to the key register (address 4). Any write to an address other than 4 disarms the unlock, whether or not it was accepted.
- R2: A write of any value other than 0x0051F15E to the key register leaves the block locked.
- R3: An accepted feed write of 0x0D09F00D clears the counter on the next clock edge. An accepted feed write of any other value leaves the counter unchanged.
- R4: The counter is 31 bits wide and rises by one per clock when config bit 12 (always run) is set, or when bit 13 (awake run) is set and `core_awake` is high. Otherwise it holds. An accepted counter write loads bus_wdata[30:0].
- R5: Config bits [2:0] hold the scale s. The block compares counter bits [s+15:s] with compare bits [15:0], and a match is present whenever that slice is greater than or equal to the compare value.
- R6: A match sets config bit 28, the pending flag, on the next edge, and `irq` equals the flag. The flag stays set until an accepted config write with bit 28 at 0. A match in the same cycle as that write takes priority over the clear.
- R7: With config bit 9 (zero-on-match) set, a match returns the counter to 0 on the next edge, unless a bus write to the counter or feed register takes priority.
- R8: With config bit 8 (reset enable) set, `rst_req` is high for exactly one cycle. That cycle follows the first cycle in which a match is present after a cycle with no match.
- R9: Writing a compare value of 0 makes the match true at once, so the pending flag sets two edges after the compare write.
- R10: After reset the block is locked, the config and counter read 0, and the compare reads 0x0000FFFF.
- R11: Read data is combinational from the address. Config reads back bits 2:0, 8, 9, 12, 13 and 28, with all other bits 0. Compare reads its 16 bits with zero extension. Feed, key and addresses 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_awake | input | 1 | High while the core is running; gates awake-run mode |
| bus_addr | input | 3 | Register word address |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | 1 | Pending flag, level |
| rst_req | output | 1 | One-cycle reset request pulse |

## Verification
The assertions assume that software never issues two bus writes in back-to-back cycles to the counter or compare registers. That matters because the reset pulse property expects a match to stay low for at least a cycle after it falls. The key rule already enforces this spacing, and the stimulus writes only in unlock/target pairs with idle cycles between them. They also assume the counter does not wrap within a run. The longest run here covers a few hundred counts, far below the 31-bit limit. The `core_awake` input changes only between edges, and the bench drives it like every other input, shortly after the rising edge.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

    localparam int DATA_W  = 32;
    localparam int CNT_W   = 31;
    localparam int CMP_W   = 16;
    localparam int SCALE_W = 3;

    localparam logic [DATA_W-1:0] UNLOCK_CODE = 32'h0051_F15E;
    localparam logic [DATA_W-1:0] FEED_CODE   = 32'h0D09_F00D;
    localparam logic [CMP_W-1:0]  CMP_RESET   = '1;

    // config field positions
    localparam int B_RST_EN  = 8;
    localparam int B_ZERO    = 9;
    localparam int B_ALWAYS  = 12;
    localparam int B_AWAKE   = 13;
    localparam int B_PENDING = 28;

    typedef enum logic [2:0] {
        SEL_CFG   = 3'd0,
        SEL_COUNT = 3'd1,
        SEL_CMP   = 3'd2,
        SEL_FEED  = 3'd3,
        SEL_KEY   = 3'd4,
        SEL_RSV5  = 3'd5,
        SEL_RSV6  = 3'd6,
        SEL_RSV7  = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic [SCALE_W-1:0] scale;
        logic               rst_en;
        logic               zero_on_match;
        logic               run_always;
        logic               run_awake;
    } wd_cfg_t;

    // Unpack the writable config fields from a bus word.
    function automatic wd_cfg_t cfg_from_word(input logic [DATA_W-1:0] w);
        wd_cfg_t c;
        c.scale         = w[SCALE_W-1:0];
        c.rst_en        = w[B_RST_EN];
        c.zero_on_match = w[B_ZERO];
        c.run_always    = w[B_ALWAYS];
        c.run_awake     = w[B_AWAKE];
        return c;
    endfunction

    // Build the config read word from fields and the pending flag.
    function automatic logic [DATA_W-1:0] cfg_to_word(input wd_cfg_t c, input logic pend);
        logic [DATA_W-1:0] w;
        w = '0;
        w[SCALE_W-1:0] = c.scale;
        w[B_RST_EN]    = c.rst_en;
        w[B_ZERO]      = c.zero_on_match;
        w[B_ALWAYS]    = c.run_always;
        w[B_AWAKE]     = c.run_awake;
        w[B_PENDING]   = pend;
        return w;
    endfunction

endpackage

// File: rtl/kwdt_unlock.sv
module kwdt_unlock
    import kwdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] wdata,
    output logic              unlocked,
    output logic              wr_ok
);

    logic armed_q;

    // a guarded write passes only if armed and not aimed at the key itself
    always_comb wr_ok = bus_we && armed_q && (sel != SEL_KEY);
    always_comb unlocked = armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
        end else if (bus_we) begin
            if (sel == SEL_KEY) armed_q <= (wdata == UNLOCK_CODE);
            else                armed_q <= 1'b0;
        end
    end

    // R1: any non-key write uses up the unlock
    a_r1_unlock_consumed: assert property (@(posedge clk) disable iff (rst)
        (bus_we && sel != SEL_KEY) |=> !unlocked);

    // R2: wrong key value leaves the block locked
    a_r2_bad_key_locks: assert property (@(posedge clk) disable iff (rst)
        (bus_we && sel == SEL_KEY && wdata != UNLOCK_CODE) |=> !unlocked);

endmodule

// File: rtl/kwdt_counter.sv
module kwdt_counter
    import kwdt_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int MW = CMP_W,
    parameter int SW = SCALE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          zero_on_match,
    input  logic          load_en,
    input  logic [CW-1:0] load_val,
    input  logic          clear_en,
    input  logic [MW-1:0] cmp_val,
    input  logic [SW-1:0] scale,
    output logic [CW-1:0] count,
    output logic          match
);

    localparam int MAX_SHIFT = (1 << SW) - 1;
    localparam logic [CW-1:0] ONE = CW'(1);

    initial begin
        if (CW < MW + MAX_SHIFT) $error("counter too narrow for the scale range");
    end

    logic [MW-1:0] slice;

    always_comb slice = count[scale +: MW];
    always_comb match = (slice >= cmp_val);

    always_ff @(posedge clk) begin
        if (rst)                         count <= '0;
        else if (load_en)                count <= load_val;
        else if (clear_en)               count <= '0;
        else if (match && zero_on_match) count <= '0;
        else if (run)                    count <= count + ONE;
    end

    // R4: running counter steps by one
    a_r4_count_step: assert property (@(posedge clk) disable iff (rst)
        (run && !load_en && !clear_en && !(match && zero_on_match))
        |=> count == $past(count) + ONE);

    // R4: stopped counter holds
    a_r4_count_hold: assert property (@(posedge clk) disable iff (rst)
        (!run && !load_en && !clear_en && !(match && zero_on_match))
        |=> $stable(count));

    // R7: zero-on-match restarts the count
    a_r7_zero_restart: assert property (@(posedge clk) disable iff (rst)
        (match && zero_on_match && !load_en) |=> count == '0);

    // R3: feed clears the count
    a_r3_feed_clears: assert property (@(posedge clk) disable iff (rst)
        (clear_en && !load_en) |=> count == '0);

endmodule

// File: rtl/kwdt_ctrl.sv
module kwdt_ctrl
    import kwdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_cfg,
    input  wd_cfg_t          cfg_wval,
    input  logic             pend_keep,
    input  logic             wr_cmp,
    input  logic [CMP_W-1:0] cmp_wval,
    input  logic             match,
    output wd_cfg_t          cfg,
    output logic [CMP_W-1:0] cmp,
    output logic             pending,
    output logic             rst_req
);

    logic match_q;
    logic pend_n;

    always_comb begin
        pend_n = pending;
        if (wr_cfg) pend_n = pending & pend_keep;
        pend_n = pend_n | match;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg     <= '0;
            cmp     <= CMP_RESET;
            pending <= 1'b0;
            match_q <= 1'b0;
            rst_req <= 1'b0;
        end else begin
            if (wr_cfg) cfg <= cfg_wval;
            if (wr_cmp) cmp <= cmp_wval;
            pending <= pend_n;
            match_q <= match;
            rst_req <= cfg.rst_en && match && !match_q;
        end
    end

    // R6: pending flag is sticky without a config write
    a_r6_pending_sticky: assert property (@(posedge clk) disable iff (rst)
        (pending && !wr_cfg) |=> pending);

    // R6: a match always sets the flag
    a_r6_match_sets: assert property (@(posedge clk) disable iff (rst)
        match |=> pending);

    // R8: reset request lasts one cycle
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);

    // R8: reset request only with reset enable
    a_r8_needs_enable: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> $past(cfg.rst_en));

endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
    import kwdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              core_awake,
    input  logic [2:0]        bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              rst_req
);

    reg_sel_e         sel;
    logic             unlocked;
    logic             wr_ok;
    wd_cfg_t          cfg;
    logic [CMP_W-1:0] cmp;
    logic             pending;
    logic [CNT_W-1:0] count;
    logic             match;
    logic             run;
    logic             wr_cfg, wr_cmp, wr_cnt, wr_feed;

    always_comb sel = reg_sel_e'(bus_addr);

    always_comb begin
        wr_cfg  = wr_ok && (sel == SEL_CFG);
        wr_cmp  = wr_ok && (sel == SEL_CMP);
        wr_cnt  = wr_ok && (sel == SEL_COUNT);
        wr_feed = wr_ok && (sel == SEL_FEED) && (bus_wdata == FEED_CODE);
        run     = cfg.run_always || (cfg.run_awake && core_awake);
    end

    kwdt_unlock u_unlock (
        .clk      (clk),
        .rst      (rst),
        .bus_we   (bus_we),
        .sel      (sel),
        .wdata    (bus_wdata),
        .unlocked (unlocked),
        .wr_ok    (wr_ok)
    );

    kwdt_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_cfg    (wr_cfg),
        .cfg_wval  (cfg_from_word(bus_wdata)),
        .pend_keep (bus_wdata[B_PENDING]),
        .wr_cmp    (wr_cmp),
        .cmp_wval  (bus_wdata[CMP_W-1:0]),
        .match     (match),
        .cfg       (cfg),
        .cmp       (cmp),
        .pending   (pending),
        .rst_req   (rst_req)
    );

    kwdt_counter #(
        .CW (CNT_W),
        .MW (CMP_W),
        .SW (SCALE_W)
    ) u_counter (
        .clk           (clk),
        .rst           (rst),
        .run           (run),
        .zero_on_match (cfg.zero_on_match),
        .load_en       (wr_cnt),
        .load_val      (bus_wdata[CNT_W-1:0]),
        .clear_en      (wr_feed),
        .cmp_val       (cmp),
        .scale         (cfg.scale),
        .count         (count),
        .match         (match)
    );

    always_comb irq = pending;

    always_comb begin
        unique case (sel)
            SEL_CFG:   bus_rdata = cfg_to_word(cfg, pending);
            SEL_COUNT: bus_rdata = DATA_W'(count);
            SEL_CMP:   bus_rdata = DATA_W'(cmp);
            default:   bus_rdata = '0;
        endcase
    end

    // R1: a locked compare write changes nothing
    a_r1_locked_cmp: assert property (@(posedge clk) disable iff (rst)
        (bus_we && !unlocked && sel == SEL_CMP) |=> $stable(cmp));

    // R1: a locked config write changes nothing
    a_r1_locked_cfg: assert property (@(posedge clk) disable iff (rst)
        (bus_we && !unlocked && sel == SEL_CFG) |=> $stable(cfg));

endmodule

// File: tb/kwdt_top_tb_top.sv
module kwdt_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        core_awake = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        rst_req;

    always #2 clk = ~clk;   // 250 MHz

    kwdt_top dut_i (
        .clk        (clk),
        .rst        (rst),
        .core_awake (core_awake),
        .bus_addr   (bus_addr),
        .bus_we     (bus_we),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .irq        (irq),
        .rst_req    (rst_req)
    );

    localparam int KEY  = 32'h0051F15E;
    localparam int FOOD = 32'h0D09F00D;

    int    n_chk = 0;
    int    n_bad = 0;
    int    cyc   = 0;
    string phase = "R10 reset";

    // behavioural reference state
    bit          m_arm;
    int unsigned m_cfg;      // config readback bits except pending
    int unsigned m_cmp;
    int unsigned m_cnt;
    bit          m_pend;
    bit          m_mprev;
    bit          m_rreq;

    function automatic bit m_match();
        int unsigned sc;
        sc = m_cfg & 7;
        return ((m_cnt >> sc) & 32'hFFFF) >= m_cmp;
    endfunction

    function automatic int unsigned m_read(input int a);
        case (a)
            0: return m_cfg | (m_pend ? 32'h1000_0000 : 0);
            1: return m_cnt;
            2: return m_cmp;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        bit m, ok, runv, acc;
        if (rst) begin
            m_arm = 0; m_cfg = 0; m_cmp = 32'hFFFF; m_cnt = 0;
            m_pend = 0; m_mprev = 0; m_rreq = 0;
        end else begin
            m = m_match();
            runv = ((m_cfg >> 12) & 1) != 0 || (((m_cfg >> 13) & 1) != 0 && core_awake);
            acc = bus_we && m_arm && bus_addr != 3'd4;
            m_rreq = ((m_cfg >> 8) & 1) != 0 && m && !m_mprev;
            m_mprev = m;
            ok = 0;
            if (acc && bus_addr == 3'd0) begin
                if (!bus_wdata[28]) m_pend = 0;
            end
            if (m) m_pend = 1;
            if (acc && bus_addr == 3'd1) begin
                m_cnt = bus_wdata & 32'h7FFF_FFFF; ok = 1;
            end else if (acc && bus_addr == 3'd3 && bus_wdata == FOOD) begin
                m_cnt = 0; ok = 1;
            end
            if (!ok) begin
                if (m && ((m_cfg >> 9) & 1) != 0) m_cnt = 0;
                else if (runv) m_cnt = (m_cnt + 1) & 32'h7FFF_FFFF;
            end
            if (acc && bus_addr == 3'd0) m_cfg = bus_wdata & 32'h0000_3307;
            if (acc && bus_addr == 3'd2) m_cmp = bus_wdata & 32'hFFFF;
            if (bus_we) m_arm = (bus_addr == 3'd4) && (bus_wdata == KEY);
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (!rst) begin
            n_chk++;
            if (bus_rdata !== m_read(int'(bus_addr))) begin
                n_bad++;
                $display("FAIL [%s] rdata@%0d got %h exp %h", phase, bus_addr, bus_rdata, m_read(int'(bus_addr)));
            end
            n_chk++;
            if (irq !== m_pend) begin
                n_bad++;
                $display("FAIL [%s] irq got %0b exp %0b", phase, irq, m_pend);
            end
            n_chk++;
            if (rst_req !== m_rreq) begin
                n_bad++;
                $display("FAIL [%s] rst_req got %0b exp %0b", phase, rst_req, m_rreq);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_bad++;
            $display("FAIL [watchdog] run hung got %0d cycles exp <= 20000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            bus_we = 0;
        end
    endtask

    task automatic wr(input int a, input int unsigned d);
        @(posedge clk); #1;
        bus_addr = 3'(a); bus_wdata = d; bus_we = 1;
        @(posedge clk); #1;
        bus_we = 0;
    endtask

    task automatic uwr(input int a, input int unsigned d);
        wr(4, KEY);
        wr(a, d);
    endtask

    task automatic look(input int a, input int n);
        bus_addr = 3'(a);
        step(n);
    endtask

    // explicit named checks on top of the per-cycle compare
    task automatic expect_rd(input string tag, input int a, input int unsigned e);
        bus_addr = 3'(a);
        @(negedge clk);
        n_chk++;
        if (bus_rdata !== e) begin
            n_bad++;
            $display("FAIL [%s] read %0d got %h exp %h", tag, a, bus_rdata, e);
        end
        @(posedge clk); #1;
    endtask

    initial begin
        step(3);
        rst = 0;
        phase = "R10 R11 reset readback";
        expect_rd("R10", 2, 32'h0000FFFF);
        expect_rd("R10", 0, 0);
        for (int a = 0; a < 8; a++) look(a, 1);

        phase = "R1 locked write";
        wr(2, 32'h0000_0040);
        expect_rd("R1", 2, 32'h0000FFFF);
        uwr(2, 32'h0000_0040);
        expect_rd("R1", 2, 32'h40);
        wr(2, 32'h0000_0010);          // unlock consumed
        expect_rd("R1", 2, 32'h40);
        wr(4, KEY); wr(6, 32'h55); wr(2, 32'h11);
        expect_rd("R1", 2, 32'h40);

        phase = "R2 bad key";
        wr(4, KEY); wr(4, 32'h1234); wr(0, 32'h1000);
        expect_rd("R2", 0, 0);

        phase = "R4 run always";
        uwr(0, 32'h0000_1000);
        look(1, 10);
        uwr(0, 32'h0000_0000);
        look(1, 5);
        phase = "R4 run awake";
        uwr(0, 32'h0000_2000);
        bus_addr = 3'd1;
        for (int i = 0; i < 12; i++) begin
            core_awake = (i % 3) != 0;
            step(1);
        end
        core_awake = 0;
        uwr(1, 32'h7FFF_0000);
        expect_rd("R4", 1, 32'h7FFF_0000);

        phase = "R3 feed";
        uwr(3, 32'h0D09_F00E);
        look(1, 2);
        uwr(3, FOOD);
        expect_rd("R3", 1, 0);

        phase = "R5 scale compare";
        uwr(2, 5);
        uwr(0, 32'h0000_1002);          // scale 2, always run
        look(0, 30);
        phase = "R6 clear while matching";
        uwr(0, 32'h0000_1002);          // bit 28 clear, match still present
        look(0, 3);
        uwr(0, 32'h0000_0002);          // stop
        uwr(3, FOOD);
        uwr(0, 32'h0000_0002);
        expect_rd("R6", 0, 32'h2);

        phase = "R7 periodic";
        uwr(2, 3);
        uwr(0, 32'h0000_1200);
        look(1, 20);
        phase = "R8 reset pulses";
        uwr(0, 32'h0000_1300);
        look(0, 20);
        uwr(0, 32'h0000_1107);          // scale 7, no zeroing
        uwr(1, 32'h0000_0170);
        look(0, 40);

        phase = "R9 compare zero";
        uwr(0, 32'h0000_0000);
        uwr(3, FOOD);
        uwr(2, 32'h0000_7000);
        uwr(0, 32'h0000_0000);
        expect_rd("R9", 0, 0);
        uwr(2, 0);
        look(0, 1);
        expect_rd("R9", 0, 32'h1000_0000);

        step(4);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule